// File: doc/BRIEF.md
# Recursive Halving Carry-Lookahead Adder

This block is a purely combinational adder. It takes two operands of `WIDTH` bits and a single carry-in bit. It returns a `WIDTH`-bit sum and a carry-out.

The operand is split into a lower and an upper part, and each part is split again until single bits remain. Every part reports three things: its sum bits, a group propagate flag and a group generate flag. The carry into an upper part is formed from the flags of its lower neighbour and the carry entering the pair. Because of this, the carry path grows with the depth of the split tree and not with the operand width.

Any width from 1 upward is accepted. For an odd width, the lower part always takes the floor of half the bits.

Top module: `pfx_adder`

## Requirements
- R1: For every pair of operands and both carry-in values, {cout, sum} equals a + b + cin taken as unsigned integers of WIDTH+1 bits.
- R2: Widths that are not powers of two, including odd widths, give the exact sum of R1. An odd width puts floor(WIDTH/2) bits in the lower part.
- R3: All-ones plus zero with cin = 1 gives sum = 0 and cout = 1. All-ones plus all-ones with cin = 1 gives sum = all-ones and cout = 1.
- R4: When every bit position propagates (b equals the bitwise inverse of a), cout equals cin and sum equals the bitwise inverse of cin replicated across the word.
- R5: Zero plus zero gives sum equal to cin in bit 0 with all other bits 0, and cout = 0.
- R6: At WIDTH = 1 the block behaves as a one-bit full adder on all eight input combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend, unsigned |
| b | input | WIDTH | Second addend, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The embedded checks are combinational. They assume that every input bit is a known 0 or 1, and each one is guarded so that it skips any evaluation in which an input is unknown. The bench drives known values onto all inputs before the first comparison and holds them steady across each sample point. This keeps every evaluation inside that assumption. Small widths are swept exhaustively over both operands and the carry-in, and a wide instance takes only directed corner vectors.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  typedef struct packed {
    logic p;
    logic g;
  } pg_t;

  function automatic int lo_width(input int w);
    return w / 2;
  endfunction
endpackage

// File: rtl/pfx_leaf.sv
module pfx_leaf
  import pfx_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic c,
  output logic s,
  output pg_t  pg
);
  always_comb begin
    pg.p = a ^ b;
    pg.g = a & b;
    s    = pg.p ^ c;
  end
endmodule

// File: rtl/pfx_merge.sv
module pfx_merge
  import pfx_pkg::*;
(
  input  pg_t lo,
  input  pg_t hi,
  output pg_t grp
);
  always_comb begin
    grp.p = lo.p & hi.p;
    grp.g = hi.g | (hi.p & lo.g);
  end

  always_comb begin
    if (!$isunknown({lo, hi}))
      assert_pg_exclusive_R1: assert (!(grp.p && grp.g))
        else $error("group propagate and generate both set");
  end
endmodule

// File: rtl/pfx_seg.sv
module pfx_seg
  import pfx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output pg_t          pg
);
  generate
    if (W == 1) begin : g_leaf
      pfx_leaf u_leaf (
        .a  (a[0]),
        .b  (b[0]),
        .c  (cin),
        .s  (sum[0]),
        .pg (pg)
      );
    end else begin : g_split
      localparam int WL = lo_width(W);
      localparam int WH = W - WL;
      pg_t  pg_lo;
      pg_t  pg_hi;
      logic c_mid;

      pfx_seg #(.W(WL)) u_lo (
        .a   (a[WL-1:0]),
        .b   (b[WL-1:0]),
        .cin (cin),
        .sum (sum[WL-1:0]),
        .pg  (pg_lo)
      );

      assign c_mid = pg_lo.g | (pg_lo.p & cin);

      pfx_seg #(.W(WH)) u_hi (
        .a   (a[W-1:WL]),
        .b   (b[W-1:WL]),
        .cin (c_mid),
        .sum (sum[W-1:WL]),
        .pg  (pg_hi)
      );

      pfx_merge u_merge (
        .lo  (pg_lo),
        .hi  (pg_hi),
        .grp (pg)
      );
    end
  endgenerate

  logic [W:0] seg_ref;
  always_comb begin
    seg_ref = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    if (!$isunknown({a, b, cin}))
      assert_seg_sum_R2: assert ({pg.g | (pg.p & cin), sum} == seg_ref)
        else $error("segment of width %0d disagrees with its own sum", W);
  end
endmodule

// File: rtl/pfx_adder.sv
module pfx_adder
  import pfx_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  pg_t pg_all;

  pfx_seg #(.W(WIDTH)) u_root (
    .a   (a),
    .b   (b),
    .cin (cin),
    .sum (sum),
    .pg  (pg_all)
  );

  assign cout = pg_all.g | (pg_all.p & cin);

  logic [WIDTH:0] total_ref;
  always_comb begin
    total_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    if (!$isunknown({a, b, cin})) begin
      assert_total_R1: assert ({cout, sum} == total_ref)
        else $error("adder result disagrees with a+b+cin");
      if ((a ^ b) == {WIDTH{1'b1}})
        assert_cout_pass_R4: assert (cout == cin)
          else $error("full propagate did not pass carry-in");
    end
  end
endmodule

// File: tb/pfx_adder_test.sv
module pfx_adder_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0]  a8, b8;   logic c8;  logic [7:0]  s8;  logic o8;
  logic [4:0]  a5, b5;   logic c5;  logic [4:0]  s5;  logic o5;
  logic        a1, b1;   logic c1;  logic        s1;  logic o1;
  logic [31:0] aw, bw;   logic cw;  logic [31:0] sw;  logic ow;

  pfx_adder #(.WIDTH(8))  uut      (.a(a8), .b(b8), .cin(c8), .sum(s8), .cout(o8));
  pfx_adder #(.WIDTH(5))  uut_odd  (.a(a5), .b(b5), .cin(c5), .sum(s5), .cout(o5));
  pfx_adder #(.WIDTH(1))  uut_one  (.a(a1), .b(b1), .cin(c1), .sum(s1), .cout(o1));
  pfx_adder #(.WIDTH(32)) uut_wide (.a(aw), .b(bw), .cin(cw), .sum(sw), .cout(ow));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wide_vec(input string tag, input logic [31:0] x, input logic [31:0] y,
                          input logic c);
    logic [32:0] e;
    @(posedge clk);
    aw = x; bw = y; cw = c;
    #3;
    e = {1'b0, x} + {1'b0, y} + {32'd0, c};
    chk(tag, {31'd0, ow, sw}, {31'd0, e});
  endtask

  initial begin
    a8 = '0; b8 = '0; c8 = 1'b0;
    a5 = '0; b5 = '0; c5 = 1'b0;
    a1 = 1'b0; b1 = 1'b0; c1 = 1'b0;
    aw = '0; bw = '0; cw = 1'b0;
    #3;
    // R5: quiescent inputs, all zeros
    chk("R5 zero+zero cin0 w8", {55'd0, o8, s8}, 64'd0);

    // R1: exhaustive sweep at width 8
    for (int i = 0; i < 131072; i++) begin
      logic [8:0] e;
      @(posedge clk);
      a8 = i[7:0]; b8 = i[15:8]; c8 = i[16];
      #3;
      e = {1'b0, a8} + {1'b0, b8} + {8'd0, c8};
      chk("R1 exhaustive w8", {55'd0, o8, s8}, {55'd0, e});
    end

    // R2: exhaustive sweep at odd width 5
    for (int i = 0; i < 2048; i++) begin
      logic [5:0] e;
      @(posedge clk);
      a5 = i[4:0]; b5 = i[9:5]; c5 = i[10];
      #3;
      e = {1'b0, a5} + {1'b0, b5} + {5'd0, c5};
      chk("R2 exhaustive w5", {58'd0, o5, s5}, {58'd0, e});
    end

    // R6: one-bit full adder
    for (int i = 0; i < 8; i++) begin
      logic [1:0] e;
      @(posedge clk);
      a1 = i[0]; b1 = i[1]; c1 = i[2];
      #3;
      e = {1'b0, a1} + {1'b0, b1} + {1'b0, c1};
      chk("R6 width1", {62'd0, o1, s1}, {62'd0, e});
    end

    // R3: all-ones with carry-in
    wide_vec("R3 ones+0+1 w32", 32'hFFFF_FFFF, 32'h0, 1'b1);
    chk("R3 ones+0+1 sum/cout", {31'd0, ow, sw}, {31'd0, 1'b1, 32'h0});
    wide_vec("R3 ones+ones+1 w32", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    chk("R3 ones+ones+1 sum/cout", {31'd0, ow, sw}, {31'd0, 1'b1, 32'hFFFF_FFFF});

    // R4: full propagate passes carry-in
    wide_vec("R4 a=~b cin0", 32'hA5C3_0F71, 32'h5A3C_F08E, 1'b0);
    chk("R4 a=~b cin0 out", {31'd0, ow, sw}, {31'd0, 1'b0, 32'hFFFF_FFFF});
    wide_vec("R4 a=~b cin1", 32'h1234_5678, 32'hEDCB_A987, 1'b1);
    chk("R4 a=~b cin1 out", {31'd0, ow, sw}, {31'd0, 1'b1, 32'h0});

    // R5: zero plus zero with carry-in
    wide_vec("R5 zero+zero cin1", 32'h0, 32'h0, 1'b1);
    chk("R5 zero+zero cin1 out", {31'd0, ow, sw}, {31'd0, 1'b0, 32'h1});

    // R1: assorted wide patterns
    wide_vec("R1 msb pair", 32'h8000_0000, 32'h8000_0000, 1'b0);
    wide_vec("R1 mid ripple", 32'h0000_FFFF, 32'h0000_0001, 1'b0);
    wide_vec("R1 alt", 32'hAAAA_AAAA, 32'h5555_5556, 1'b1);
    for (int i = 0; i < 200; i++) begin
      logic [31:0] x, y;
      x = 32'h9E37_79B9 * i[31:0] + 32'h1357;
      y = 32'h85EB_CA6B ^ (x << 3) ^ i[31:0];
      wide_vec("R1 scattered w32", x, y, i[0]);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule